// File: doc/BRIEF.md
# Frame Transfer DMA Control Register Bank

This block is the software-visible control point of a two-way frame transfer engine. A processor with a plain single-cycle bus (write strobe, read strobe, word offset, 32-bit data) programs it. It holds three buffer base addresses: one for outgoing frames, one for incoming data frames and one for incoming frames of every other type. It also holds the parameters of the next transmission. It turns control-word writes into one-cycle command pulses for the transmit engine. It keeps the status that the engines report back: an error code, the received word count and the type of the last received frame. It also holds two sticky interrupt lines.

The bus map is asymmetric, so a read and a write at the same offset reach different storage. Offset 0x04 writes the non-data receive base but reads the error code. Offset 0x0C writes the data receive base but reads the receive status. Every write to the control word also clears the received word count, ready for the next transfer. Read data is registered, so it appears in the cycle after the read strobe.

Top module: `fis_dma_regbank`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, every output is zero.
- R2: A write to offset 0x00 (transmit base), 0x04 (non-data receive base) or 0x0C (data receive base) updates the matching address output at the next clock edge. Bits [8:0] of the stored value are forced to zero, so every address is 512-byte aligned.
- R3: A write to offset 0x08 (control) loads `tx_is_data` from bit 29 (1 = data frame, 0 = other) and `tx_word_cnt` from bits [15:0]. Both hold until the next control write.
- R4: In a control write, bit 30 produces a one-cycle `tx_start` pulse and bit 31 produces a one-cycle `hw_reset` pulse, each in the cycle after the write. Neither bit can be read back.
- R5: `bus_rdata` is registered. It carries the selected value in the cycle after `bus_rd` is high, and is zero in any cycle not preceded by a read. Reads at 0x00, 0x08, 0x10 and at any offset other than 0x04 or 0x0C return zero.
- R6: A read at 0x04 returns the error code latched on the last `err_upd` pulse, zero-extended to 32 bits. A write to 0x04 leaves it unchanged.
- R7: A read at 0x0C returns the received frame type flag in bit 31 (1 = non-data, 0 = data) and the received word count in bits [23:0]. Bits [30:24] are zero. Count and flag are latched on `rx_cnt_upd` and `rx_type_upd` respectively.
- R8: Any control write clears the received word count. If `rx_cnt_upd` arrives in the same cycle, the new count is kept.
- R9: A write to offset 0x10 with bit 29 set clears the received type flag. If `rx_type_upd` arrives in the same cycle, the new type is kept.
- R10: `irq_e2c` is set by `e2c_done` and `irq_c2e` is set by `c2e_done`. Each stays high until a write to 0x10 with bit 31 (for `irq_e2c`) or bit 30 (for `irq_c2e`). When set and clear occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_base_addr | output | 32 | Transmit buffer base, aligned |
| rx_ndata_addr | output | 32 | Receive base for non-data frames, aligned |
| rx_data_addr | output | 32 | Receive base for data frames, aligned |
| tx_start | output | 1 | One-cycle transmit start pulse |
| hw_reset | output | 1 | One-cycle engine reset pulse |
| tx_is_data | output | 1 | Type of the frame to transmit |
| tx_word_cnt | output | 16 | Words to transmit |
| rx_cnt_upd | input | 1 | Receive engine count update strobe |
| rx_cnt_val | input | 24 | Received word count |
| rx_type_upd | input | 1 | Received frame type update strobe |
| rx_type_nondata | input | 1 | 1 when the received frame is not a data frame |
| err_upd | input | 1 | Error code update strobe |
| err_val | input | 8 | Error code from the engines |
| e2c_done | input | 1 | Engine-to-processor completion pulse |
| c2e_done | input | 1 | Processor-to-engine completion pulse |
| irq_e2c | output | 1 | Engine-to-processor interrupt |
| irq_c2e | output | 1 | Processor-to-engine interrupt |

## Verification
The bench targets the shared offsets 0x04 and 0x0C. A design that decoded reads and writes alike would return a base address where the error code or receive status belongs. It also checks that the command bits cannot be read back, and that they are cleared by the following edge. A latched start bit would restart the engine on every cycle. Same-cycle collisions are exercised: interrupt set against clear, count update against a control write, and type update against a type clear. A wrong priority would drop a completion that arrives just as software acknowledges the previous one. Aligned-address masking and zero reads at the write-only and unmapped offsets are checked, since a leak at either would point a DMA engine at a misaligned buffer or return stale values to software.

// File: rtl/fdr_pkg.sv
package fdr_pkg;

    localparam int DATA_W     = 32;
    localparam int OFS_W      = 5;
    localparam int ALIGN_BITS = 9;
    localparam int WCNT_W     = 16;
    localparam int RCNT_W     = 24;
    localparam int ERR_W      = 8;

    // byte offsets
    localparam logic [OFS_W-1:0] OFS_TXA  = 5'h00;
    localparam logic [OFS_W-1:0] OFS_RXN  = 5'h04;
    localparam logic [OFS_W-1:0] OFS_CTRL = 5'h08;
    localparam logic [OFS_W-1:0] OFS_RXD  = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_ICLR = 5'h10;

    // control word bits
    localparam int BIT_HWRST = 31;
    localparam int BIT_START = 30;
    localparam int BIT_TYPE  = 29;

    // interrupt clear word bits
    localparam int BIT_CLR_E2C  = 31;
    localparam int BIT_CLR_C2E  = 30;
    localparam int BIT_CLR_TYPE = 29;

    typedef enum logic [2:0] {
        WR_NONE, WR_TXA, WR_RXN, WR_CTRL, WR_RXD, WR_ICLR
    } wr_sel_e;

    typedef enum logic [1:0] {
        RD_ZERO, RD_ERR, RD_RXST
    } rd_sel_e;

    function automatic wr_sel_e dec_wr(input logic wr, input logic [OFS_W-1:0] ofs);
        wr_sel_e s;
        s = WR_NONE;
        if (wr) begin
            unique case (ofs)
                OFS_TXA:  s = WR_TXA;
                OFS_RXN:  s = WR_RXN;
                OFS_CTRL: s = WR_CTRL;
                OFS_RXD:  s = WR_RXD;
                OFS_ICLR: s = WR_ICLR;
                default:  s = WR_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic rd_sel_e dec_rd(input logic [OFS_W-1:0] ofs);
        rd_sel_e s;
        unique case (ofs)
            OFS_RXN: s = RD_ERR;
            OFS_RXD: s = RD_RXST;
            default: s = RD_ZERO;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fdr_base_reg.sv
module fdr_base_reg #(
    parameter int DW    = 32,
    parameter int ALIGN = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    logic low_unused;
    assign low_unused = ^wdata[ALIGN-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= {wdata[DW-1:ALIGN], {ALIGN{1'b0}}};
    end
endmodule

// File: rtl/fdr_sticky_flag.sv
module fdr_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);

    // R10
    drop_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q) |-> $past(clr));
endmodule

// File: rtl/fdr_rx_status.sv
module fdr_rx_status #(
    parameter int RCNT_W = 24,
    parameter int ERR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_upd,
    input  logic [RCNT_W-1:0] cnt_val,
    input  logic              cnt_clr,
    input  logic              type_upd,
    input  logic              type_nondata,
    input  logic              type_clr,
    input  logic              err_upd,
    input  logic [ERR_W-1:0]  err_val,
    output logic [RCNT_W-1:0] cnt_q,
    output logic              type_q,
    output logic [ERR_W-1:0]  err_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            type_q <= 1'b0;
            err_q  <= '0;
        end else begin
            if (cnt_upd)       cnt_q <= cnt_val;
            else if (cnt_clr)  cnt_q <= '0;
            if (type_upd)      type_q <= type_nondata;
            else if (type_clr) type_q <= 1'b0;
            if (err_upd)       err_q <= err_val;
        end
    end

    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr && !cnt_upd) |=> (cnt_q == '0));

    // R9
    type_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (type_clr && !type_upd) |=> !type_q);
endmodule

// File: rtl/fis_dma_regbank.sv
module fis_dma_regbank
    import fdr_pkg::*;
#(
    parameter int DW  = fdr_pkg::DATA_W,
    parameter int AW  = fdr_pkg::OFS_W,
    parameter int TCW = fdr_pkg::WCNT_W,
    parameter int RCW = fdr_pkg::RCNT_W,
    parameter int EW  = fdr_pkg::ERR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [DW-1:0]  tx_base_addr,
    output logic [DW-1:0]  rx_ndata_addr,
    output logic [DW-1:0]  rx_data_addr,
    output logic           tx_start,
    output logic           hw_reset,
    output logic           tx_is_data,
    output logic [TCW-1:0] tx_word_cnt,
    input  logic           rx_cnt_upd,
    input  logic [RCW-1:0] rx_cnt_val,
    input  logic           rx_type_upd,
    input  logic           rx_type_nondata,
    input  logic           err_upd,
    input  logic [EW-1:0]  err_val,
    input  logic           e2c_done,
    input  logic           c2e_done,
    output logic           irq_e2c,
    output logic           irq_c2e
);
    localparam int NADDR = 3;
    localparam int NIRQ  = 2;

    wr_sel_e wsel;
    rd_sel_e rsel;
    logic    wr_ctrl, wr_iclr;

    always_comb begin
        wsel    = dec_wr(bus_wr, bus_addr);
        rsel    = dec_rd(bus_addr);
        wr_ctrl = (wsel == WR_CTRL);
        wr_iclr = (wsel == WR_ICLR);
    end

    // aligned base address registers
    logic [NADDR-1:0]  addr_we;
    logic [DW-1:0]     addr_q [NADDR];
    assign addr_we = {wsel == WR_RXD, wsel == WR_RXN, wsel == WR_TXA};

    for (genvar i = 0; i < NADDR; i++) begin : g_addr
        fdr_base_reg #(.DW(DW), .ALIGN(ALIGN_BITS)) u_base (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (addr_we[i]),
            .wdata (bus_wdata),
            .q     (addr_q[i])
        );
    end
    assign tx_base_addr  = addr_q[0];
    assign rx_ndata_addr = addr_q[1];
    assign rx_data_addr  = addr_q[2];

    // control word and command pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_is_data  <= 1'b0;
            tx_word_cnt <= '0;
            tx_start    <= 1'b0;
            hw_reset    <= 1'b0;
        end else begin
            tx_start <= wr_ctrl && bus_wdata[BIT_START];
            hw_reset <= wr_ctrl && bus_wdata[BIT_HWRST];
            if (wr_ctrl) begin
                tx_is_data  <= bus_wdata[BIT_TYPE];
                tx_word_cnt <= bus_wdata[TCW-1:0];
            end
        end
    end

    // receive status
    logic [RCW-1:0] rcnt_q;
    logic           rtype_q;
    logic [EW-1:0]  err_q;

    fdr_rx_status #(.RCNT_W(RCW), .ERR_W(EW)) u_rxst (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_upd      (rx_cnt_upd),
        .cnt_val      (rx_cnt_val),
        .cnt_clr      (wr_ctrl),
        .type_upd     (rx_type_upd),
        .type_nondata (rx_type_nondata),
        .type_clr     (wr_iclr && bus_wdata[BIT_CLR_TYPE]),
        .err_upd      (err_upd),
        .err_val      (err_val),
        .cnt_q        (rcnt_q),
        .type_q       (rtype_q),
        .err_q        (err_q)
    );

    // interrupt flags
    logic [NIRQ-1:0] irq_set, irq_clr, irq_q;
    assign irq_set = {c2e_done, e2c_done};
    assign irq_clr = {wr_iclr && bus_wdata[BIT_CLR_C2E], wr_iclr && bus_wdata[BIT_CLR_E2C]};

    for (genvar k = 0; k < NIRQ; k++) begin : g_irq
        fdr_sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (irq_set[k]),
            .clr   (irq_clr[k]),
            .q     (irq_q[k])
        );
    end
    assign irq_e2c = irq_q[0];
    assign irq_c2e = irq_q[1];

    // registered read port
    logic [DW-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        unique case (rsel)
            RD_ERR:  rd_mux[EW-1:0] = err_q;
            RD_RXST: begin
                rd_mux[RCW-1:0] = rcnt_q;
                rd_mux[DW-1]    = rtype_q;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    // R4
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(bus_wr && bus_addr == OFS_CTRL && bus_wdata[BIT_START]));

    // R4
    hwrst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_reset |-> $past(bus_wr && bus_addr == OFS_CTRL && bus_wdata[BIT_HWRST]));

    // R5
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> (bus_rdata == '0));

    // R3
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_ctrl) |-> $stable(tx_word_cnt));
endmodule

// File: tb/fis_dma_regbank_test.sv
module fis_dma_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, tx_base_addr, rx_ndata_addr, rx_data_addr;
    logic        tx_start, hw_reset, tx_is_data, irq_e2c, irq_c2e;
    logic [15:0] tx_word_cnt;
    logic        rx_cnt_upd = 0, rx_type_upd = 0, rx_type_nondata = 0, err_upd = 0;
    logic [23:0] rx_cnt_val = '0;
    logic [7:0]  err_val = '0;
    logic        e2c_done = 0, c2e_done = 0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    fis_dma_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_base_addr(tx_base_addr), .rx_ndata_addr(rx_ndata_addr),
        .rx_data_addr(rx_data_addr), .tx_start(tx_start), .hw_reset(hw_reset),
        .tx_is_data(tx_is_data), .tx_word_cnt(tx_word_cnt),
        .rx_cnt_upd(rx_cnt_upd), .rx_cnt_val(rx_cnt_val),
        .rx_type_upd(rx_type_upd), .rx_type_nondata(rx_type_nondata),
        .err_upd(err_upd), .err_val(err_val), .e2c_done(e2c_done),
        .c2e_done(c2e_done), .irq_e2c(irq_e2c), .irq_c2e(irq_c2e)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
    endtask

    // vector: {addr[4:0], data[31:0], sel[2:0], expected[31:0]}
    // sel 0..2 address outputs, 3 {tx_is_data,tx_word_cnt}, 4 read result
    localparam int NV = 11;
    localparam logic [71:0] VEC [0:NV-1] = '{
        {5'h00, 32'h1234_56FF, 3'd0, 32'h1234_5600},
        {5'h04, 32'hAAAA_A3FF, 3'd1, 32'hAAAA_A200},
        {5'h0C, 32'hFFFF_FFFF, 3'd2, 32'hFFFF_FE00},
        {5'h08, 32'h2000_0123, 3'd3, 32'h0001_0123},
        {5'h08, 32'h0000_FFFF, 3'd3, 32'h0000_FFFF},
        {5'h00, 32'h0,         3'd4, 32'h0},
        {5'h08, 32'h0,         3'd4, 32'h0},
        {5'h10, 32'h0,         3'd4, 32'h0},
        {5'h14, 32'h0,         3'd4, 32'h0},
        {5'h04, 32'h0,         3'd4, 32'h0},
        {5'h0C, 32'h0,         3'd4, 32'h0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 addr", tx_base_addr | rx_ndata_addr | rx_data_addr, 32'h0);
        chk("R1 ctl", {26'h0, tx_start, hw_reset, tx_is_data, irq_e2c, irq_c2e, 1'b0} | {16'h0, tx_word_cnt} | bus_rdata, 32'h0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 post", {tx_start, hw_reset, irq_e2c, irq_c2e} , 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [4:0]  a;
            logic [31:0] d, e;
            logic [2:0]  s;
            {a, d, s, e} = VEC[i];
            if (s == 3'd4) begin
                rd(a);
                chk("R5 R6 R11 read", bus_rdata, e);
            end else begin
                wr(a, d);
                case (s)
                    3'd0: chk("R2 txa", tx_base_addr, e);
                    3'd1: chk("R2 rxn", rx_ndata_addr, e);
                    3'd2: chk("R2 rxd", rx_data_addr, e);
                    default: chk("R3 ctrl", {15'h0, tx_is_data, tx_word_cnt}, e);
                endcase
            end
        end

        // R4 start pulse
        wr(5'h08, 32'h4000_0010);
        chk("R4 start", {31'h0, tx_start}, 1);
        chk("R4 nohw", {31'h0, hw_reset}, 0);
        @(negedge clk);
        chk("R4 start drop", {31'h0, tx_start}, 0);
        wr(5'h08, 32'h8000_0000);
        chk("R4 hwrst", {31'h0, hw_reset}, 1);
        @(negedge clk);
        chk("R4 hwrst drop", {31'h0, hw_reset}, 0);
        rd(5'h08);
        chk("R4 readback", bus_rdata, 0);

        // R6 error code, untouched by a write at 0x04
        @(negedge clk); err_upd = 1; err_val = 8'hA5;
        @(negedge clk); err_upd = 0;
        wr(5'h04, 32'hFFFF_FE00);
        rd(5'h04);
        chk("R6 err", bus_rdata, 32'h0000_00A5);
        @(negedge clk);
        chk("R5 idle", bus_rdata, 0);

        // R7 status
        @(negedge clk); rx_cnt_upd = 1; rx_cnt_val = 24'hABCDEF; rx_type_upd = 1; rx_type_nondata = 1;
        @(negedge clk); rx_cnt_upd = 0; rx_type_upd = 0;
        rd(5'h0C);
        chk("R7 rxst", bus_rdata, 32'h80AB_CDEF);

        // R8 clear by control write, then collision
        wr(5'h08, 32'h0);
        rd(5'h0C);
        chk("R8 clr", bus_rdata, 32'h8000_0000);
        @(negedge clk);
        bus_wr = 1; bus_addr = 5'h08; bus_wdata = 0; rx_cnt_upd = 1; rx_cnt_val = 24'd7;
        @(negedge clk);
        bus_wr = 0; rx_cnt_upd = 0;
        rd(5'h0C);
        chk("R8 upd wins", bus_rdata, 32'h8000_0007);

        // R9 type clear and collision
        wr(5'h10, 32'h2000_0000);
        rd(5'h0C);
        chk("R9 clr", bus_rdata, 32'h0000_0007);
        @(negedge clk);
        bus_wr = 1; bus_addr = 5'h10; bus_wdata = 32'h2000_0000; rx_type_upd = 1; rx_type_nondata = 1;
        @(negedge clk);
        bus_wr = 0; rx_type_upd = 0;
        rd(5'h0C);
        chk("R9 upd wins", bus_rdata, 32'h8000_0007);

        // R10 interrupts
        @(negedge clk); e2c_done = 1; c2e_done = 1;
        @(negedge clk); e2c_done = 0; c2e_done = 0;
        repeat (3) @(negedge clk);
        chk("R10 sticky", {30'h0, irq_e2c, irq_c2e}, 32'h3);
        wr(5'h10, 32'h8000_0000);
        chk("R10 clr e2c", {30'h0, irq_e2c, irq_c2e}, 32'h1);
        wr(5'h10, 32'h4000_0000);
        chk("R10 clr c2e", {30'h0, irq_e2c, irq_c2e}, 32'h0);
        @(negedge clk);
        bus_wr = 1; bus_addr = 5'h10; bus_wdata = 32'hC000_0000; e2c_done = 1;
        @(negedge clk);
        bus_wr = 0; e2c_done = 0;
        chk("R10 set wins", {30'h0, irq_e2c, irq_c2e}, 32'h2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule